// File: doc/BRIEF.md
# Serial-Controlled Dual Channel Gate

This block is a target on a two-wire serial bus (I2C) that owns one 8-bit control byte. The two lowest bits of that byte switch two downstream channel paths on or off. Two upper bits let the bus controller see whether either downstream side is raising an interrupt. A combined active-low interrupt output is also driven toward the upstream side.

The upstream clock and data lines are brought into the system clock domain through synchronisers. START, STOP and clock edges are found on the synchronised copies. A byte-level state machine handles the transfer. It receives the address byte and acknowledges only its own address. It then either accepts written bytes, acknowledging each one, or shifts out the control byte on reads until the controller declines with a NACK. A written value is held as pending and reaches the channel-enable outputs only when the STOP that closes the transfer is seen.

Two active-low inputs reset the block asynchronously: a general reset and a power-on reset. Either one clears the enables and returns the state machine to idle.

States: IDLE (bus free), ADDR (shifting in the address byte), ADDR_ACK (driving the address acknowledge), WR_DATA (shifting in a written byte), WR_ACK (driving the data acknowledge), RD_DATA (shifting out the control byte), RD_ACK (sampling the controller's acknowledge) and WAIT_STOP (ignoring the bus until the next START or STOP).

Transitions:
- START from any state goes to ADDR.
- STOP from any state goes to IDLE.
- ADDR goes to ADDR_ACK after the eighth bit when the address matches, and to WAIT_STOP when it does not.
- ADDR_ACK goes to WR_DATA or RD_DATA, depending on the direction bit.
- WR_DATA goes to WR_ACK after eight bits. WR_ACK goes back to WR_DATA.
- RD_DATA goes to RD_ACK after eight bits.
- RD_ACK goes to RD_DATA on an ACK and to WAIT_STOP on a NACK.

Top module: `i2c_chswitch_ctrl`

## Requirements
- R1: When reset is released, chan_en is 2'b00, sda_oe is 0 and int_out_n is 1 while both int_in_n inputs are high.
- R2: The block pulls SDA low (sda_oe=1) during the ninth clock of an address byte only when the address matches. On a mismatch it leaves SDA released for the rest of the transfer, ignores its data bytes and leaves chan_en unchanged.
- R3: The 7-bit target address is {ADDR_HI, addr_pins}. The first byte after START carries the address in bits 7:1 and the direction in bit 0, where 0 means write and 1 means read.
- R4: A written byte's bits 1:0 become chan_en. Bit 0 enables channel 0 and bit 1 enables channel 1. Bits 7:2 of a written byte have no effect, and every written byte is acknowledged.
- R5: A written value reaches chan_en only after the STOP that ends the transfer. Up to that STOP, chan_en keeps its old value, including across a repeated START.
- R6: A read returns {2'b00, irq1, irq0, 2'b00, chan_en}, most significant bit first. irq1 (bit 5) is 1 when int_in_n[1] is low, and irq0 (bit 4) is 1 when int_in_n[0] is low.
- R7: int_out_n is low when either int_in_n bit is low, and high when both are high, within three clock cycles.
- R8: After the controller sends ACK on a read byte, the control byte is sent again. After a NACK, SDA stays released until the next START or STOP.
- R9: Pulling rst_n low, even in the middle of a transfer, clears chan_en, drops any pending write and releases SDA. The next transfer works normally.
- R10: Pulling por_n low clears chan_en to 2'b00, the same as rst_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| por_n | input | 1 | Power-on reset, active low |
| addr_pins | input | 2 | Low two bits of the target address |
| scl_in | input | 1 | Upstream bus clock line as seen |
| sda_in | input | 1 | Upstream bus data line as seen |
| sda_oe | output | 1 | 1 pulls the data line low |
| int_in_n | input | 2 | Downstream interrupt inputs, active low |
| int_out_n | output | 1 | Combined interrupt, active low |
| chan_en | output | 2 | Channel enables (bit 0 is channel 0) |

## Verification
A wrong state or bit count shows up at the ports within one byte time. The acknowledge lands on the wrong clock or goes missing, and the read byte comes out shifted or corrupted. A stale pending value or a missed commit shows up on chan_en in the cycles just after the STOP. A missed reset or a lost STOP shows up as a wrong value on the first read of the next transfer. Each of these is compared against values the bench predicts from the bus traffic alone.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int CH_N   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_WAIT_STOP
    } bus_state_e;
endpackage

// File: rtl/i2csw_sync.sv
module i2csw_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[g] <= RST_VAL;
            end else begin
                if (g == 0) stage[g] <= d;
                else        stage[g] <= stage[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/i2csw_cond_det.sv
module i2csw_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // a data edge counts as a condition only while the clock was high on both samples
    assign start_det = scl_q & scl & sda_q & ~sda;
    assign stop_det  = scl_q & scl & ~sda_q & sda;
    assign scl_rise  = ~scl_q & scl;
    assign scl_fall  = scl_q & ~scl;
endmodule

// File: rtl/i2csw_fsm.sv
module i2csw_fsm
    import i2csw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              en_load,
    output logic [CH_N-1:0]   en_val,
    output logic              bus_idle
);
    bus_state_e              state, state_nx;
    logic [BYTE_W-1:0]       shreg;
    logic [CNT_W-1:0]        bit_cnt;
    logic                    nack_q;
    logic [CH_N-1:0]         pend;
    logic                    pend_vld;

    wire byte_done = (bit_cnt == CNT_W'(BYTE_W));
    wire addr_hit  = (shreg[BYTE_W-1:1] == dev_addr);
    wire rd_last   = (bit_cnt == CNT_W'(BYTE_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_done)
                                  state_nx = addr_hit ? ST_ADDR_ACK : ST_WAIT_STOP;
                ST_ADDR_ACK:  if (scl_fall)
                                  state_nx = shreg[0] ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:   if (scl_fall && byte_done) state_nx = ST_WR_ACK;
                ST_WR_ACK:    if (scl_fall) state_nx = ST_WR_DATA;
                ST_RD_DATA:   if (scl_fall && rd_last) state_nx = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall)
                                  state_nx = nack_q ? ST_WAIT_STOP : ST_RD_DATA;
                ST_WAIT_STOP: state_nx = ST_WAIT_STOP;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            nack_q   <= 1'b1;
            pend     <= '0;
            pend_vld <= 1'b0;
        end else if (stop_det) begin
            pend_vld <= 1'b0;
            bit_cnt  <= '0;
        end else if (start_det) begin
            bit_cnt  <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_DATA: begin
                    if (scl_rise && !byte_done) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (scl_fall && byte_done && state == ST_WR_DATA) begin
                        pend     <= shreg[CH_N-1:0];
                        pend_vld <= 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (shreg[0]) shreg <= rd_byte;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) bit_cnt <= '0;
                end
                ST_RD_DATA: begin
                    if (scl_fall && !rd_last) begin
                        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) nack_q <= sda_s;
                    if (scl_fall && !nack_q) begin
                        shreg   <= rd_byte;
                        bit_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe   = 1'b0;
        bus_idle = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_DATA:             sda_oe = ~shreg[BYTE_W-1];
            ST_IDLE:                bus_idle = 1'b1;
            default:                sda_oe = 1'b0;
        endcase
        en_load = stop_det & pend_vld;
        en_val  = pend;
    end
endmodule

// File: rtl/i2c_chswitch_ctrl.sv
module i2c_chswitch_ctrl
    import i2csw_pkg::*;
#(
    parameter logic [4:0] ADDR_HI     = 5'b11100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            por_n,
    input  logic [1:0]      addr_pins,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            sda_oe,
    input  logic [CH_N-1:0] int_in_n,
    output logic            int_out_n,
    output logic [CH_N-1:0] chan_en
);
    logic            rst_int_n;
    logic [1:0]      bus_s;
    logic [CH_N-1:0] int_s;
    logic            start_det, stop_det, scl_rise, scl_fall;
    logic            en_load;
    logic [CH_N-1:0] en_val;
    logic            bus_idle;
    logic [BYTE_W-1:0] rd_byte;

    assign rst_int_n = rst_n & por_n;

    i2csw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
        .clk(clk), .rst_n(rst_int_n), .d({scl_in, sda_in}), .q(bus_s)
    );

    i2csw_sync #(.WIDTH(CH_N), .STAGES(SYNC_STAGES), .RST_VAL({CH_N{1'b1}})) u_int_sync (
        .clk(clk), .rst_n(rst_int_n), .d(int_in_n), .q(int_s)
    );

    i2csw_cond_det u_cond (
        .clk(clk), .rst_n(rst_int_n), .scl(bus_s[1]), .sda(bus_s[0]),
        .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    assign rd_byte = {2'b00, ~int_s[1], ~int_s[0], 2'b00, chan_en};

    i2csw_fsm u_fsm (
        .clk(clk), .rst_n(rst_int_n),
        .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(bus_s[0]),
        .dev_addr({ADDR_HI, addr_pins}), .rd_byte(rd_byte),
        .sda_oe(sda_oe), .en_load(en_load), .en_val(en_val), .bus_idle(bus_idle)
    );

    always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n)   chan_en <= '0;
        else if (en_load) chan_en <= en_val;
    end

    assign int_out_n = &int_s;
endmodule

// File: rtl/i2csw_checker.sv
module i2csw_checker (
    input logic       clk,
    input logic       rst_int_n,
    input logic       stop_det,
    input logic       scl_s,
    input logic       bus_idle,
    input logic       sda_oe,
    input logic [1:0] int_in_n,
    input logic       int_out_n,
    input logic [1:0] chan_en
);
    logic [2:0] cyc;

    always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n)      cyc <= '0;
        else if (cyc != 3'd7) cyc <= cyc + 1'b1;
    end

    AST_EN_ONLY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_int_n)
        (cyc != 3'd0 && !$stable(chan_en)) |-> $past(stop_det)); // R5

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
        bus_idle |-> !sda_oe); // R2

    AST_DRIVE_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
        (cyc != 3'd0 && !$stable(sda_oe)) |-> !scl_s); // R2

    AST_RESET_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_int_n)
        (cyc == 3'd1) |-> (chan_en == 2'b00 && !sda_oe)); // R9

    AST_INT_COMBINE: assert property (@(posedge clk) disable iff (!rst_int_n)
        (cyc >= 3'd4 && $stable(int_in_n) && $past($stable(int_in_n))
                     && $past($stable(int_in_n), 2))
        |-> (int_out_n == &int_in_n)); // R7
endmodule

bind i2c_chswitch_ctrl i2csw_checker u_chk (
    .clk(clk), .rst_int_n(rst_int_n), .stop_det(stop_det), .scl_s(bus_s[1]),
    .bus_idle(bus_idle), .sda_oe(sda_oe), .int_in_n(int_in_n),
    .int_out_n(int_out_n), .chan_en(chan_en)
);

// File: tb/i2c_chswitch_ctrl_bench.sv
module i2c_chswitch_ctrl_bench;
    localparam int HALF = 12;
    localparam int QTR  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_n = 1'b0;
    logic [1:0] addr_pins = 2'b10;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [1:0] int_in_n = 2'b11;
    logic       int_out_n;
    logic [1:0] chan_en;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_chswitch_ctrl u_i2c_chswitch_ctrl (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr_pins(addr_pins),
        .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
        .int_in_n(int_in_n), .int_out_n(int_out_n), .chan_en(chan_en)
    );

    typedef struct {
        string req;
        string what;
        int    val;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    // scoreboard: the driver pushes expectation, then the observation
    task automatic chk(input string req, input string what, input int act, input int exp);
        item_t e, a;
        e.req = req; e.what = what; e.val = exp;
        a.req = req; a.what = what; a.val = act;
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            item_t e, a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_checks++;
            if (e.val != a.val) begin
                n_fail++;
                $display("FAIL %s %s: actual %0h expected %0h", e.req, e.what, a.val, e.val);
            end
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitc(HALF);
        scl_m = 1'b1; waitc(HALF);
        sda_m = 1'b0; waitc(HALF);
        scl_m = 1'b0; waitc(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitc(HALF);
        scl_m = 1'b1; waitc(HALF);
        sda_m = 1'b1; waitc(HALF);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitc(HALF);
            scl_m = 1'b1; waitc(HALF);
            scl_m = 1'b0; waitc(QTR);
        end
        sda_m = 1'b1; waitc(HALF);
        scl_m = 1'b1; waitc(HALF / 2);
        ack = sda_bus;
        waitc(HALF / 2);
        scl_m = 1'b0; waitc(QTR);
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b, output int drove);
        drove = 0;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitc(HALF);
            scl_m = 1'b1; waitc(HALF / 2);
            b[i] = sda_bus;
            if (sda_oe) drove++;
            waitc(HALF / 2);
            scl_m = 1'b0; waitc(QTR);
        end
        sda_m = mack; waitc(HALF);
        scl_m = 1'b1; waitc(HALF);
        scl_m = 1'b0; waitc(QTR);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                            input string req, input logic exp_ack);
        logic ack;
        bus_start();
        wr_byte({a, 1'b0}, ack);
        chk(req, "addr ack", ack, exp_ack ? 0 : 1);
        wr_byte(d, ack);
        chk(req, "data ack", ack, exp_ack ? 0 : 1);
        chk("R5", "enable before stop", chan_en, chan_en_model);
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] exp, input string req);
        logic ack;
        logic [7:0] b;
        int drove;
        bus_start();
        wr_byte({a, 1'b1}, ack);
        chk(req, "read addr ack", ack, 0);
        rd_byte(1'b1, b, drove);
        chk(req, "read byte", b, exp);
        bus_stop();
    endtask

    logic [1:0] chan_en_model = 2'b00;

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : drive
        logic ack;
        logic [7:0] b;
        int drove;

        waitc(5);
        chk("R1", "reset chan_en", chan_en, 0);
        chk("R1", "reset sda_oe", sda_oe, 0);
        rst_n = 1'b1; por_n = 1'b1;
        waitc(5);
        chk("R1", "after reset chan_en", chan_en, 0);
        chk("R1", "after reset int_out_n", int_out_n, 1);
        chk("R1", "after reset sda_oe", sda_oe, 0);

        // R3 address 0x72 with pins 10; R4 upper bits ignored
        do_write(7'h72, 8'hFF, "R3", 1'b1);
        chan_en_model = 2'b11;
        waitc(4);
        chk("R4", "chan_en after stop", chan_en, 3);
        do_read(7'h72, 8'h03, "R6");

        // R7 interrupt combine and R6 bit placement
        int_in_n = 2'b01; waitc(4);
        chk("R7", "int_out_n ch1 low", int_out_n, 0);
        do_read(7'h72, 8'h23, "R6");
        int_in_n = 2'b10; waitc(4);
        chk("R7", "int_out_n ch0 low", int_out_n, 0);
        do_read(7'h72, 8'h13, "R6");
        int_in_n = 2'b00; waitc(4);
        do_read(7'h72, 8'h33, "R6");
        int_in_n = 2'b11; waitc(4);
        chk("R7", "int_out_n both high", int_out_n, 1);

        // R2 wrong address: no ack, data ignored
        do_write(7'h70, 8'h00, "R2", 1'b0);
        waitc(4);
        chk("R2", "chan_en unchanged", chan_en, 3);

        // R3 pins change the address
        addr_pins = 2'b00;
        do_write(7'h70, 8'h01, "R3", 1'b1);
        chan_en_model = 2'b01;
        waitc(4);
        chk("R3", "chan_en new address", chan_en, 1);

        // R4 upper bits discarded
        do_write(7'h70, 8'hFE, "R4", 1'b1);
        chan_en_model = 2'b10;
        waitc(4);
        chk("R4", "chan_en from 0xFE", chan_en, 2);
        do_read(7'h70, 8'h02, "R4");

        // R8 ACK repeats the byte, NACK releases the line
        bus_start();
        wr_byte({7'h70, 1'b1}, ack);
        chk("R8", "addr ack", ack, 0);
        rd_byte(1'b0, b, drove);
        chk("R8", "first byte", b, 8'h02);
        rd_byte(1'b1, b, drove);
        chk("R8", "second byte", b, 8'h02);
        rd_byte(1'b1, b, drove);
        chk("R8", "line after nack", b, 8'hFF);
        chk("R8", "drive after nack", drove, 0);
        bus_stop();

        // R5 repeated start keeps old enable until stop
        bus_start();
        wr_byte({7'h70, 1'b0}, ack);
        wr_byte(8'h01, ack);
        chk("R5", "data ack", ack, 0);
        bus_start();
        wr_byte({7'h70, 1'b1}, ack);
        chk("R5", "rs addr ack", ack, 0);
        rd_byte(1'b1, b, drove);
        chk("R5", "read old value", b, 8'h02);
        chk("R5", "chan_en before stop", chan_en, 2);
        bus_stop();
        waitc(4);
        chk("R5", "chan_en after stop", chan_en, 1);

        // R9 reset mid-transfer
        bus_start();
        wr_byte({7'h70, 1'b0}, ack);
        wr_byte(8'h03, ack);
        rst_n = 1'b0; waitc(3);
        chk("R9", "chan_en in reset", chan_en, 0);
        chk("R9", "sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1; waitc(3);
        bus_stop();
        waitc(4);
        chk("R9", "pending dropped", chan_en, 0);
        do_read(7'h70, 8'h00, "R9");

        // R10 power-on reset
        chan_en_model = 2'b00;
        do_write(7'h70, 8'h03, "R10", 1'b1);
        waitc(4);
        chk("R10", "chan_en before por", chan_en, 3);
        por_n = 1'b0; waitc(3);
        chk("R10", "chan_en in por", chan_en, 0);
        por_n = 1'b1; waitc(4);
        chk("R10", "chan_en after por", chan_en, 0);

        waitc(4);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule